// File: doc/BRIEF.md
# CCD Binning Readout Sequencer

This block produces the digital phase pulses that read a CCD image array out with programmable on-sensor charge binning. A start strobe captures the array height and width, a vertical grouping factor, a horizontal grouping factor and a settle delay. The block then walks the array one line group at a time. For each line group it moves several rows of charge into the serial register, so that they add together there. It then clocks that register out in groups of serial shifts into the summing well, with one well reset before each group and one converter sample strobe after each group.

Each sample taken this way covers a super-pixel of up to vertical-factor by horizontal-factor original pixels. A factor of one on both axes gives plain pixel-by-pixel readout. Groups at the bottom or right edge that are only partly filled still produce one sample each. A one-cycle frame-done pulse ends the frame. The outputs are decoded from a registered state, so at most one phase pulse is active in any clock cycle.

Top module: `ccd_bin_seq`

## Requirements
- R1: A start seen while idle, with rows, columns and both factors all nonzero, is accepted. In the next cycle busy is high and par_shift is high. A start with any of these four fields equal to zero is ignored and busy stays low.
- R2: Each line group begins with min(V, rows still unread) consecutive par_shift cycles. Across the frame, par_shift is active exactly once per row.
- R3: Each column group is one well_rst cycle followed at once by exactly H consecutive ser_shift cycles. The final, partial group also gets H shifts, so the serial register is always flushed by a whole number of groups.
- R4: After the last ser_shift of a group, exactly settle idle cycles pass, then adc_sample is high for one cycle. With settle equal to 0, the sample comes in the cycle right after the last shift.
- R5: Each line group yields ceil(columns/H) samples and the frame has ceil(rows/V) line groups. After a sample that is not the last in its line group, well_rst follows in the next cycle. After the last sample of a line group that is not the last, par_shift follows in the next cycle.
- R6: The cycle after the last sample of the frame, frame_done is high for one cycle, and busy is low in the cycle after that.
- R7: Busy is high from the cycle after an accepted start through the frame_done cycle, and it is low at all other times.
- R8: Start pulses and changes to the configuration inputs while busy have no effect on the pulse sequence of the frame that is running.
- R9: par_shift and ser_shift are never active in the same cycle. At most one of par_shift, ser_shift, well_rst, adc_sample and frame_done is high in any cycle.
- R10: While reset is asserted and in the first cycle after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame readout |
| cfg_rows | input | DIM_W | Array row count |
| cfg_cols | input | DIM_W | Array column count |
| cfg_vbin | input | DIM_W | Rows summed per line group (V) |
| cfg_hbin | input | DIM_W | Serial shifts per sample (H) |
| cfg_settle | input | SET_W | Idle cycles between the last shift of a group and the sample |
| par_shift | output | 1 | Parallel-register shift step |
| ser_shift | output | 1 | Serial-register shift into the summing well |
| well_rst | output | 1 | Summing-well reset |
| adc_sample | output | 1 | Converter sample strobe |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is a frame in which partial groups on both axes meet: the last line group holds fewer than V rows while each line also ends in a column group that holds fewer than H columns. The flush, the remaining-row clipping and the end-of-frame handoff then all fall in a few adjacent cycles. The stimulus uses sizes such as 7 rows by 10 columns binned 3 by 4, plus a case where V exceeds the row count, and it compares every cycle with a per-cycle pulse list built from the configuration. A further frame fires extra start pulses and rewrites every configuration input in the middle of the readout, so any leak of live inputs into the running sequence shows up as a mismatch.

// File: rtl/ccd_bin_pkg.sv
package ccd_bin_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_VSHIFT,
        SQ_WELLCLR,
        SQ_HSHIFT,
        SQ_SETTLE,
        SQ_SAMPLE,
        SQ_FINISH
    } seq_state_e;

    typedef struct packed {
        logic busy;
        logic par;
        logic ser;
        logic wclr;
        logic smp;
        logic fin;
    } phase_t;

    function automatic phase_t phase_of(input seq_state_e st);
        phase_t p;
        p      = '0;
        p.busy = (st != SQ_IDLE);
        p.par  = (st == SQ_VSHIFT);
        p.ser  = (st == SQ_HSHIFT);
        p.wclr = (st == SQ_WELLCLR);
        p.smp  = (st == SQ_SAMPLE);
        p.fin  = (st == SQ_FINISH);
        return p;
    endfunction

endpackage

// File: rtl/ccd_bin_cfg_latch.sv
module ccd_bin_cfg_latch #(
    parameter int DIM_W = 12,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             busy,
    input  logic [DIM_W-1:0] rows_i,
    input  logic [DIM_W-1:0] cols_i,
    input  logic [DIM_W-1:0] vbin_i,
    input  logic [DIM_W-1:0] hbin_i,
    input  logic [SET_W-1:0] settle_i,
    output logic             accept,
    output logic [DIM_W-1:0] cols_q,
    output logic [DIM_W-1:0] vbin_q,
    output logic [DIM_W-1:0] hbin_q,
    output logic [SET_W-1:0] settle_q
);

    logic fields_ok;

    assign fields_ok = (rows_i != '0) && (cols_i != '0) &&
                       (vbin_i != '0) && (hbin_i != '0);
    assign accept    = start && !busy && fields_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cols_q   <= '0;
            vbin_q   <= '0;
            hbin_q   <= '0;
            settle_q <= '0;
        end else if (accept) begin
            cols_q   <= cols_i;
            vbin_q   <= vbin_i;
            hbin_q   <= hbin_i;
            settle_q <= settle_i;
        end
    end

endmodule

// File: rtl/ccd_bin_fsm.sv
module ccd_bin_fsm
    import ccd_bin_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [DIM_W-1:0] rows_i,
    input  logic [DIM_W-1:0] cols_i,
    input  logic [DIM_W-1:0] vbin_i,
    input  logic [DIM_W-1:0] cols_q,
    input  logic [DIM_W-1:0] vbin_q,
    input  logic [DIM_W-1:0] hbin_q,
    input  logic [SET_W-1:0] settle_q,
    output seq_state_e       state
);

    localparam logic [DIM_W-1:0] ONE_D = DIM_W'(1);
    localparam logic [SET_W-1:0] ONE_S = SET_W'(1);

    logic [DIM_W-1:0] rows_left;
    logic [DIM_W-1:0] cols_left;
    logic [DIM_W-1:0] step_left;
    logic [SET_W-1:0] wait_left;

    function automatic logic [DIM_W-1:0] lesser(input logic [DIM_W-1:0] a,
                                                input logic [DIM_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            rows_left <= '0;
            cols_left <= '0;
            step_left <= '0;
            wait_left <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        state     <= SQ_VSHIFT;
                        rows_left <= rows_i;
                        cols_left <= cols_i;
                        step_left <= lesser(vbin_i, rows_i) - ONE_D;
                    end
                end
                SQ_VSHIFT: begin
                    rows_left <= rows_left - ONE_D;
                    if (step_left == '0) begin
                        state <= SQ_WELLCLR;
                    end else begin
                        step_left <= step_left - ONE_D;
                    end
                end
                SQ_WELLCLR: begin
                    step_left <= hbin_q - ONE_D;
                    state     <= SQ_HSHIFT;
                end
                SQ_HSHIFT: begin
                    if (step_left == '0) begin
                        cols_left <= (cols_left > hbin_q) ? (cols_left - hbin_q) : '0;
                        if (settle_q == '0) begin
                            state <= SQ_SAMPLE;
                        end else begin
                            wait_left <= settle_q - ONE_S;
                            state     <= SQ_SETTLE;
                        end
                    end else begin
                        step_left <= step_left - ONE_D;
                    end
                end
                SQ_SETTLE: begin
                    if (wait_left == '0) begin
                        state <= SQ_SAMPLE;
                    end else begin
                        wait_left <= wait_left - ONE_S;
                    end
                end
                SQ_SAMPLE: begin
                    if (cols_left != '0) begin
                        state <= SQ_WELLCLR;
                    end else if (rows_left == '0) begin
                        state <= SQ_FINISH;
                    end else begin
                        state     <= SQ_VSHIFT;
                        cols_left <= cols_q;
                        step_left <= lesser(vbin_q, rows_left) - ONE_D;
                    end
                end
                SQ_FINISH: state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ccd_bin_phase_dec.sv
module ccd_bin_phase_dec
    import ccd_bin_pkg::*;
(
    input  seq_state_e state,
    output phase_t     phase
);

    always_comb begin
        phase = phase_of(state);
    end

endmodule

// File: rtl/ccd_bin_seq.sv
module ccd_bin_seq
    import ccd_bin_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIM_W-1:0] cfg_rows,
    input  logic [DIM_W-1:0] cfg_cols,
    input  logic [DIM_W-1:0] cfg_vbin,
    input  logic [DIM_W-1:0] cfg_hbin,
    input  logic [SET_W-1:0] cfg_settle,
    output logic             par_shift,
    output logic             ser_shift,
    output logic             well_rst,
    output logic             adc_sample,
    output logic             busy,
    output logic             frame_done
);

    logic             accept;
    logic [DIM_W-1:0] cols_q;
    logic [DIM_W-1:0] vbin_q;
    logic [DIM_W-1:0] hbin_q;
    logic [SET_W-1:0] settle_q;
    seq_state_e       state;
    phase_t           phase;

    ccd_bin_cfg_latch #(.DIM_W(DIM_W), .SET_W(SET_W)) i_cfg (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (phase.busy),
        .rows_i   (cfg_rows),
        .cols_i   (cfg_cols),
        .vbin_i   (cfg_vbin),
        .hbin_i   (cfg_hbin),
        .settle_i (cfg_settle),
        .accept   (accept),
        .cols_q   (cols_q),
        .vbin_q   (vbin_q),
        .hbin_q   (hbin_q),
        .settle_q (settle_q)
    );

    ccd_bin_fsm #(.DIM_W(DIM_W), .SET_W(SET_W)) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .rows_i   (cfg_rows),
        .cols_i   (cfg_cols),
        .vbin_i   (cfg_vbin),
        .cols_q   (cols_q),
        .vbin_q   (vbin_q),
        .hbin_q   (hbin_q),
        .settle_q (settle_q),
        .state    (state)
    );

    ccd_bin_phase_dec i_dec (
        .state (state),
        .phase (phase)
    );

    assign par_shift  = phase.par;
    assign ser_shift  = phase.ser;
    assign well_rst   = phase.wclr;
    assign adc_sample = phase.smp;
    assign busy       = phase.busy;
    assign frame_done = phase.fin;

endmodule

// File: rtl/ccd_bin_seq_chk.sv
module ccd_bin_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic par_shift,
    input logic ser_shift,
    input logic well_rst,
    input logic adc_sample,
    input logic busy,
    input logic frame_done
);

    // R9
    par_ser_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(par_shift && ser_shift));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({par_shift, ser_shift, well_rst, adc_sample, frame_done}));

    // R3
    clr_then_shift_chk: assert property (@(posedge clk) disable iff (rst)
        well_rst |=> ser_shift);

    // R6
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !busy);

    // R1
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(start) && par_shift));

    // R4
    sample_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        adc_sample |-> busy);

endmodule

bind ccd_bin_seq ccd_bin_seq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .par_shift  (par_shift),
    .ser_shift  (ser_shift),
    .well_rst   (well_rst),
    .adc_sample (adc_sample),
    .busy       (busy),
    .frame_done (frame_done)
);

// File: tb/test_ccd_bin_seq.sv
module test_ccd_bin_seq;

    localparam int DW = 8;
    localparam int SW = 4;
    // expected-vector bit weights: busy par ser wrst adc done
    localparam int B_BUSY = 32, B_PAR = 16, B_SER = 8, B_WR = 4, B_ADC = 2, B_DONE = 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [DW-1:0] cfg_rows, cfg_cols, cfg_vbin, cfg_hbin;
    logic [SW-1:0] cfg_settle;
    logic          par_shift, ser_shift, well_rst, adc_sample, busy, frame_done;

    int    exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    int    adc_seen = 0;
    string tag = "R10";

    always #5 clk = ~clk;

    ccd_bin_seq #(.DIM_W(DW), .SET_W(SW)) i_ccd_bin_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_vbin(cfg_vbin),
        .cfg_hbin(cfg_hbin), .cfg_settle(cfg_settle),
        .par_shift(par_shift), .ser_shift(ser_shift), .well_rst(well_rst),
        .adc_sample(adc_sample), .busy(busy), .frame_done(frame_done)
    );

    task automatic build_frame(input int r, input int c, input int v,
                               input int h, input int s);
        int rr = r;
        while (rr > 0) begin
            int n = (v < rr) ? v : rr;
            for (int k = 0; k < n; k++) exp_q.push_back(B_BUSY + B_PAR);
            rr -= n;
            for (int cc = c; cc > 0; cc -= ((h < cc) ? h : cc)) begin
                exp_q.push_back(B_BUSY + B_WR);
                for (int k = 0; k < h; k++) exp_q.push_back(B_BUSY + B_SER);
                for (int k = 0; k < s; k++) exp_q.push_back(B_BUSY);
                exp_q.push_back(B_BUSY + B_ADC);
            end
        end
        exp_q.push_back(B_BUSY + B_DONE);
    endtask

    // behavioural reference: one list entry per clock cycle of the frame
    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
        end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
        end else if (start && cfg_rows != 0 && cfg_cols != 0 &&
                     cfg_vbin != 0 && cfg_hbin != 0) begin
            build_frame(int'(cfg_rows), int'(cfg_cols), int'(cfg_vbin),
                        int'(cfg_hbin), int'(cfg_settle));
        end
    end

    function automatic string bit_tag(input int d);
        if (d & B_PAR)  return "R2";
        if (d & B_SER)  return "R3";
        if (d & B_WR)   return "R3";
        if (d & B_ADC)  return "R4";
        if (d & B_DONE) return "R6";
        return "R7";
    endfunction

    always @(negedge clk) begin
        int act, expv;
        cycles++;
        if (!rst) begin
            act  = {26'd0, busy, par_shift, ser_shift, well_rst, adc_sample, frame_done};
            expv = (exp_q.size() != 0) ? exp_q[0] : 0;
            n_cmp++;
            if (act != expv) begin
                n_bad++;
                $display("FAIL %s/%s t=%0t actual=%06b expected=%06b",
                         tag, bit_tag(act ^ expv), $time, act[5:0], expv[5:0]);
            end
            if (adc_sample) adc_seen++;
            n_cmp++;
            if (par_shift && ser_shift) begin
                n_bad++;
                $display("FAIL R9 t=%0t actual=par&ser expected=exclusive", $time);
            end
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected=<100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic set_cfg(input int r, input int c, input int v, input int h, input int s);
        cfg_rows   = DW'(r);
        cfg_cols   = DW'(c);
        cfg_vbin   = DW'(v);
        cfg_hbin   = DW'(h);
        cfg_settle = SW'(s);
    endtask

    task automatic run_frame(input string t, input int r, input int c, input int v,
                             input int h, input int s, input bit noisy);
        int want;
        tag = t;
        @(negedge clk);
        set_cfg(r, c, v, h, s);
        adc_seen = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (noisy) begin
            // R8: restart attempts and new settings mid-frame
            repeat (5) @(negedge clk);
            set_cfg(2, 2, 1, 1, 0);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            set_cfg(9, 1, 7, 2, 9);
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        want = ((r + v - 1) / v) * ((c + h - 1) / h);
        n_cmp++;
        // R5: samples per frame
        if (adc_seen != want) begin
            n_bad++;
            $display("FAIL R5 %s actual=%0d samples expected=%0d", t, adc_seen, want);
        end
    endtask

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        set_cfg(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        n_cmp++;
        // R10: outputs quiet during reset
        if ({busy, par_shift, ser_shift, well_rst, adc_sample, frame_done} != 6'b0) begin
            n_bad++;
            $display("FAIL R10 actual=%b expected=000000",
                     {busy, par_shift, ser_shift, well_rst, adc_sample, frame_done});
        end
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_frame("R2_1x1", 3, 4, 1, 1, 0, 1'b0);
        run_frame("R5_2x2", 4, 4, 2, 2, 0, 1'b0);
        run_frame("R3_partial", 7, 10, 3, 4, 2, 1'b0);
        run_frame("R4_settle", 3, 5, 2, 2, 5, 1'b0);
        run_frame("R6_fullbin", 5, 5, 5, 5, 1, 1'b0);
        run_frame("R8_noisy", 4, 6, 2, 3, 3, 1'b0 | 1'b1);
        run_frame("R5_vclip", 2, 3, 4, 1, 0, 1'b0);

        // R1: start with a zero factor is ignored
        tag = "R1";
        set_cfg(4, 4, 0, 2, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        run_frame("R1_after", 2, 2, 1, 2, 0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule